// File: doc/BRIEF.md
# Bit-Band Alias Address Translator

This block sits between a bus master and a zero-wait, word-addressed memory or register file. It watches every request address for a hit in one of two alias windows. Each 32-bit word inside an alias window stands for exactly one bit of a matching base region: one base region holds on-chip SRAM and the other holds peripheral registers. An alias read fetches the base word and returns only the chosen bit. An alias write becomes a hidden read-modify-write: the base word is read, one bit is replaced, and the word is written back. Requests that miss both alias windows go straight through to the memory port unchanged.

The upstream side is a request/ready bus. The master holds `reqValid`, `reqWrite`, `reqAddr` and `reqWdata` steady until it sees `reqReady` high at a rising clock edge. Read data on `rspRdata` is valid in that same cycle. The downstream side is a single word port with combinational read data. The region bases, the alias bases and the size of each base region are parameters. Atomicity against other masters and any caching are outside this block.

Top module: `bitband_bridge`

## Requirements
- R1: A request whose address lies outside both alias windows reaches the memory port in the same cycle with unchanged address, write flag and write data. `reqReady` is high in that cycle, and for a read `rspRdata` equals `memRdata`.
- R2: For an alias address A in region i, where offset = A minus the alias base of region i, the target word is the base of region i plus (offset >> 5) with its two low bits cleared. The bit index is (offset >> 2) mod 32. The defaults are base 0x2000_0000 with alias 0x2200_0000, and base 0x4000_0000 with alias 0x4200_0000, each with a 1 MB base region (32 MB alias window).
- R3: An alias read takes one cycle with `reqReady` high. It issues exactly one downstream read of the target word and returns the target bit in `rspRdata[0]`, with bits 31..1 zero.
- R4: An alias write takes two downstream cycles. The first is a read of the target word with `reqReady` low. The second is a write to the same word with `reqReady` high.
- R5: On an alias write only `reqWdata[0]` matters: 1 sets the target bit and 0 clears it. Bits 31..1 of the write data have no effect.
- R6: An alias write leaves every other bit of the target word, and every other memory word, unchanged.
- R7: The alias window ends exactly at its alias base plus 32 MB. The address one word past the window is passed through unchanged. The last alias word maps to bit 31 of the last base word.
- R8: During and right after reset, with no request present, `memEn` is low and `reqReady` is high. The first alias write after reset starts with its read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Upstream request present |
| reqWrite | input | 1 | Request is a write when high |
| reqAddr | input | 32 | Upstream byte address |
| reqWdata | input | 32 | Upstream write data |
| reqReady | output | 1 | Request completes at this rising edge |
| rspRdata | output | 32 | Read data, valid while reqReady is high |
| memEn | output | 1 | Downstream access enable |
| memWe | output | 1 | Downstream write enable |
| memAddr | output | 32 | Downstream word byte address |
| memWdata | output | 32 | Downstream write data |
| memRdata | input | 32 | Downstream read data, combinational on memAddr |

## Verification
Pass-through accesses and alias reads produce their results in the same cycle the request appears, since the downstream read data is combinational. Alias writes finish one cycle later, on the write-back cycle. The bench drives each request on a falling edge and samples the ports two nanoseconds later, well before the next rising edge, in every cycle until it sees `reqReady` high. This gives a per-cycle record of downstream reads, writes, addresses and data. That record is compared with a cycle count of one for pass-through and alias reads and two for alias writes. The bench's own memory image is compared word by word at the end to confirm that alias writes disturbed no other bits.

// File: rtl/bb_pkg.sv
package bb_pkg;

  localparam int BB_ADDR_W = 32;
  localparam int BB_DATA_W = 32;
  localparam int BB_BIT_W  = $clog2(BB_DATA_W);
  localparam int BB_NREG   = 2;

  localparam logic [BB_NREG-1:0][BB_ADDR_W-1:0] BB_BASE_DEF  = {32'h4000_0000, 32'h2000_0000};
  localparam logic [BB_NREG-1:0][BB_ADDR_W-1:0] BB_ALIAS_DEF = {32'h4200_0000, 32'h2200_0000};

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_WBACK = 1'b1
  } bbState_t;

  typedef struct packed {
    logic memEn;    // drive a downstream access
    logic memWe;    // that access is a write
    logic capture;  // latch the read word for the modify step
    logic useMod;   // write the modified word instead of request data
    logic ready;    // request completes this cycle
  } bbStrobe_t;

endpackage

// File: rtl/bb_region_decode.sv
module bb_region_decode
  import bb_pkg::*;
#(
  parameter int NREG      = BB_NREG,
  parameter int ADDR_W    = BB_ADDR_W,
  parameter int SPAN_LOG2 = 20,
  parameter logic [NREG-1:0][ADDR_W-1:0] BASE  = BB_BASE_DEF,
  parameter logic [NREG-1:0][ADDR_W-1:0] ALIAS = BB_ALIAS_DEF
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NREG-1:0]     hitVec,
  output logic                hit,
  output logic [ADDR_W-1:0]   wordAddr,
  output logic [BB_BIT_W-1:0] bitIdx
);

  // every base byte expands to 8 alias words of 4 bytes
  localparam int ALIAS_LOG2 = SPAN_LOG2 + 5;
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

  logic [NREG-1:0][ADDR_W-1:0] offs;
  logic [NREG-1:0][ADDR_W-1:0] wordVec;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_region
      assign offs[g]    = addr - ALIAS[g];
      assign hitVec[g]  = (addr >= ALIAS[g]) && ((offs[g] >> ALIAS_LOG2) == '0);
      assign wordVec[g] = BASE[g] + ((offs[g] >> 5) & WORD_MASK);
    end
  endgenerate

  always_comb begin
    hit      = |hitVec;
    wordAddr = '0;
    bitIdx   = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hitVec[i]) begin
        wordAddr = wordAddr | wordVec[i];
        bitIdx   = bitIdx | offs[i][BB_BIT_W+1:2];
      end
    end
  end

endmodule

// File: rtl/bb_control.sv
module bb_control
  import bb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      aliasHit,
  output bbStrobe_t strb
);

  bbState_t state, stateNxt;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        strb.memEn   = reqValid;
        strb.memWe   = reqValid && reqWrite && !aliasHit;
        strb.capture = reqValid && reqWrite && aliasHit;
        strb.ready   = !strb.capture;
        if (strb.capture) stateNxt = ST_WBACK;
      end
      ST_WBACK: begin
        strb.memEn  = 1'b1;
        strb.memWe  = 1'b1;
        strb.useMod = 1'b1;
        strb.ready  = 1'b1;
        stateNxt    = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  // R4: the read half of an alias write is followed by its write-back
  p_rmw_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (strb.memWe && strb.useMod && strb.ready));

  // R4: a modified write-back only ever follows a capture cycle
  p_wback_after_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.useMod |-> $past(strb.capture));

  // R4: while the read half is in flight the master is held
  p_hold_master_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (!strb.ready && strb.memEn && !strb.memWe));

  // R8: no downstream traffic without a request outside write-back
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && !strb.useMod) |-> (!strb.memEn && strb.ready));

endmodule

// File: rtl/bb_datapath.sv
module bb_datapath
  import bb_pkg::*;
#(
  parameter int NREG      = BB_NREG,
  parameter int ADDR_W    = BB_ADDR_W,
  parameter int SPAN_LOG2 = 20,
  parameter logic [NREG-1:0][ADDR_W-1:0] BASE  = BB_BASE_DEF,
  parameter logic [NREG-1:0][ADDR_W-1:0] ALIAS = BB_ALIAS_DEF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bbStrobe_t            strb,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [BB_DATA_W-1:0] reqWdata,
  input  logic [BB_DATA_W-1:0] memRdata,
  output logic                 aliasHit,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [BB_DATA_W-1:0] memWdata,
  output logic [BB_DATA_W-1:0] rspRdata
);

  logic [NREG-1:0]      hitVec;
  logic [ADDR_W-1:0]    wordAddr;
  logic [BB_BIT_W-1:0]  bitIdx;
  logic [BB_DATA_W-1:0] savedWord;
  logic [BB_DATA_W-1:0] modWord;

  bb_region_decode #(
    .NREG      (NREG),
    .ADDR_W    (ADDR_W),
    .SPAN_LOG2 (SPAN_LOG2),
    .BASE      (BASE),
    .ALIAS     (ALIAS)
  ) u_decode (
    .addr     (reqAddr),
    .hitVec   (hitVec),
    .hit      (aliasHit),
    .wordAddr (wordAddr),
    .bitIdx   (bitIdx)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             savedWord <= '0;
    else if (strb.capture) savedWord <= memRdata;
  end

  always_comb begin
    modWord         = savedWord;
    modWord[bitIdx] = reqWdata[0];
  end

  assign memAddr  = aliasHit ? wordAddr : reqAddr;
  assign memWdata = strb.useMod ? modWord : reqWdata;
  assign rspRdata = aliasHit ? {{(BB_DATA_W-1){1'b0}}, memRdata[bitIdx]} : memRdata;

  // R2: the two alias windows never overlap
  p_region_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R2: write-back lands on the word that was read
  p_same_word_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.useMod |-> (memAddr == $past(memAddr)));

  // R6: write-back changes at most one bit of the captured word
  p_one_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.useMod |-> ($countones(memWdata ^ savedWord) <= 1));

  // R3: alias reads are zero-extended single bits
  p_zero_ext_r3: assert property (@(posedge clk) disable iff (!rstN)
    (aliasHit && strb.memEn && !strb.memWe && strb.ready) |-> (rspRdata[BB_DATA_W-1:1] == '0));

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int NREG      = BB_NREG,
  parameter int SPAN_LOG2 = 20,
  parameter logic [NREG-1:0][BB_ADDR_W-1:0] BASE  = BB_BASE_DEF,
  parameter logic [NREG-1:0][BB_ADDR_W-1:0] ALIAS = BB_ALIAS_DEF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [BB_ADDR_W-1:0] reqAddr,
  input  logic [BB_DATA_W-1:0] reqWdata,
  output logic                 reqReady,
  output logic [BB_DATA_W-1:0] rspRdata,
  output logic                 memEn,
  output logic                 memWe,
  output logic [BB_ADDR_W-1:0] memAddr,
  output logic [BB_DATA_W-1:0] memWdata,
  input  logic [BB_DATA_W-1:0] memRdata
);

  bbStrobe_t strb;
  logic      aliasHit;

  bb_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .aliasHit (aliasHit),
    .strb     (strb)
  );

  bb_datapath #(
    .NREG      (NREG),
    .ADDR_W    (BB_ADDR_W),
    .SPAN_LOG2 (SPAN_LOG2),
    .BASE      (BASE),
    .ALIAS     (ALIAS)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memRdata (memRdata),
    .aliasHit (aliasHit),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .rspRdata (rspRdata)
  );

  assign reqReady = strb.ready;
  assign memEn    = strb.memEn;
  assign memWe    = strb.memWe;

endmodule

// File: tb/bitband_bridge_bench.sv
`timescale 1ns/100ps
module bitband_bridge_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady;
  logic [31:0] rspRdata;
  logic        memEn;
  logic        memWe;
  logic [31:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata;

  int vectors = 0;
  int fails   = 0;
  bit finished = 1'b0;

  logic [31:0] mem    [64];
  logic [31:0] refMem [64];

  always #2.5 clk = ~clk;

  bitband_bridge u_bitband_bridge (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspRdata(rspRdata), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  function automatic logic [5:0] idxOf(input logic [31:0] a);
    return a[7:2] ^ {a[30], 5'b0} ^ {1'b0, a[19:15]};
  endfunction

  assign memRdata = mem[idxOf(memAddr)];

  always @(posedge clk) if (memEn && memWe) mem[idxOf(memAddr)] <= memWdata;

  // expected translation, from R2
  function automatic void xlate(input logic [31:0] a, output bit isAl,
                                output logic [31:0] wa, output int b);
    logic [31:0] bases [2];
    logic [31:0] aliases [2];
    logic [31:0] off;
    bases[0] = 32'h2000_0000; aliases[0] = 32'h2200_0000;
    bases[1] = 32'h4000_0000; aliases[1] = 32'h4200_0000;
    isAl = 1'b0; wa = a; b = 0;
    for (int i = 0; i < 2; i++) begin
      if (a >= aliases[i] && a < aliases[i] + 32'h0200_0000) begin
        off  = a - aliases[i];
        isAl = 1'b1;
        wa   = bases[i] + ((off / 32) & 32'hFFFF_FFFC);
        b    = int'((off / 4) % 32);
      end
    end
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doTxn(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                       output logic [31:0] rd, output int cyc, output int nRd, output int nWr,
                       output logic [31:0] firstAddr, output logic [31:0] lastWdata,
                       output logic firstRdy);
    logic rdy;
    cyc = 0; nRd = 0; nWr = 0; firstAddr = '0; lastWdata = '0; rd = '0; firstRdy = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    for (int k = 0; k < 6; k++) begin
      #2;
      cyc++;
      if (memEn) begin
        if (memWe) begin nWr++; lastWdata = memWdata; end
        else nRd++;
        if (cyc == 1) firstAddr = memAddr;
      end
      rdy = reqReady;
      if (cyc == 1) firstRdy = rdy;
      rd = rspRdata;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
  endtask

  task automatic applyTxn(input logic wr, input logic [31:0] addr, input logic [31:0] wd, input string tag);
    logic [31:0] rd, fa, lw, expW;
    int cyc, nRd, nWr, b;
    logic fr;
    bit isAl;
    logic [31:0] wa;
    xlate(addr, isAl, wa, b);
    doTxn(wr, addr, wd, rd, cyc, nRd, nWr, fa, lw, fr);
    if (!isAl) begin
      check(cyc == 1 && fr, {tag, " R1 cycles"}, cyc, 1);
      check(fa == addr, {tag, " R1 addr"}, fa, addr);
      if (wr) begin
        check(nWr == 1 && nRd == 0 && lw == wd, {tag, " R1 wdata"}, lw, wd);
        refMem[idxOf(addr)] = wd;
      end else begin
        check(nRd == 1 && nWr == 0 && rd == refMem[idxOf(addr)], {tag, " R1 rdata"}, rd, refMem[idxOf(addr)]);
      end
    end else if (!wr) begin
      check(cyc == 1 && nRd == 1 && nWr == 0, {tag, " R3 one read"}, cyc, 1);
      check(fa == wa, {tag, " R2 read addr"}, fa, wa);
      check(rd == {31'b0, refMem[idxOf(wa)][b]}, {tag, " R3 rdata"}, rd, {31'b0, refMem[idxOf(wa)][b]});
    end else begin
      expW = refMem[idxOf(wa)];
      expW[b] = wd[0];
      check(cyc == 2 && !fr && nRd == 1 && nWr == 1, {tag, " R4 two cycles"}, cyc, 2);
      check(fa == wa, {tag, " R2 rmw addr"}, fa, wa);
      check(lw == expW, {tag, " R5 R6 wdata"}, lw, expW);
      refMem[idxOf(wa)] = expW;
    end
  endtask

  function automatic logic [31:0] aliasOf(input int region, input logic [31:0] byteOff, input int bitN);
    logic [31:0] ab;
    ab = (region == 0) ? 32'h2200_0000 : 32'h4200_0000;
    return ab + byteOff * 32 + bitN * 4;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] addr, wd, off;
    int kind, reg0, bitN, w;
    for (int i = 0; i < 64; i++) begin
      mem[i]    = 32'h9E37_79B9 * (i + 1);
      refMem[i] = 32'h9E37_79B9 * (i + 1);
    end
    void'($urandom(32'd4051));
    repeat (3) @(negedge clk);
    #2;
    check(!memEn && reqReady, "R8 in reset", {memEn, reqReady}, 32'h1);
    rstN = 1'b1;
    @(negedge clk); #2;
    check(!memEn && reqReady, "R8 after reset", {memEn, reqReady}, 32'h1);

    // directed corners
    applyTxn(1'b1, aliasOf(0, 32'h4, 3), 32'h0000_0001, "R8 first rmw set");
    applyTxn(1'b0, aliasOf(0, 32'h4, 3), 32'h0, "R3 readback set");
    applyTxn(1'b1, aliasOf(0, 32'h4, 3), 32'hFFFF_FFFE, "R5 upper bits ignored clear");
    applyTxn(1'b0, aliasOf(0, 32'h4, 3), 32'h0, "R5 readback cleared");
    applyTxn(1'b1, aliasOf(1, 32'h0, 31), 32'h1, "R2 region1 bit31");
    applyTxn(1'b0, 32'h23FF_FFFC, 32'h0, "R7 last alias word read");
    applyTxn(1'b1, 32'h23FF_FFFC, 32'h0, "R7 last alias word clear");
    applyTxn(1'b0, 32'h200F_FFFC, 32'h0, "R7 base word direct");
    applyTxn(1'b1, 32'h2400_0000, 32'hCAFE_F00D, "R7 past window write");
    applyTxn(1'b0, 32'h2400_0000, 32'h0, "R7 past window read");
    applyTxn(1'b0, 32'h21FF_FFFC, 32'h0, "R1 just below window");

    // random mix
    for (int n = 0; n < 400; n++) begin
      kind = $urandom % 4;
      reg0 = $urandom % 2;
      w    = $urandom % 9;
      bitN = $urandom % 32;
      off  = (w == 8) ? 32'h000F_FFFC : 32'(w * 4) + 32'($urandom % 4);
      wd   = $urandom;
      if (kind < 2) addr = aliasOf(reg0, off, bitN);
      else if (kind == 2) addr = ((reg0 == 0) ? 32'h2000_0000 : 32'h4000_0000) + (off & 32'hFFFF_FFFC);
      else addr = 32'h0000_1000 + 32'(($urandom % 16) * 4);
      applyTxn(1'($urandom % 2), addr, wd, "rand");
    end

    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 64; i++)
      check(mem[i] == refMem[i], "R6 memory image", mem[i], refMem[i]);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule